// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the slave-side protocol engine for a two-wire serial bus, placed in front of a serial memory array. It runs on a fast system clock that oversamples SCL and SDA. It finds Start and Stop conditions, shifts address and data bytes in with the most significant bit first, and pulls SDA low during the ninth clock of each byte it accepts. On reads it shifts bytes out and checks whether the master acknowledges each one. SDA is driven in open-drain style: `sda_oe` high means pull the line low, and low means release it.

Received write bytes go to the memory side as a one-cycle `rx_valid` pulse with `rx_data`. Read bytes are taken from `tx_data` at the start of each read byte. A `tx_req` pulse then tells the memory side that the byte has been captured and the next one should be presented. While `busy_i` reports an internal programming cycle, the slave does not acknowledge anything.

The controller has these states:
- `ST_IDLE`: waits for a Start.
- `ST_ADDR`: receives the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_WR`: receives a write byte.
- `ST_WR_ACK`: acknowledges a write byte.
- `ST_RD`: sends a read byte.
- `ST_RD_ACK`: samples the master's acknowledge.
- `ST_SKIP`: keeps SDA released and waits for the next Start or Stop.

These transitions take priority over all others:
- A Start in any state moves to `ST_ADDR`.
- A Stop in any state moves to `ST_IDLE`.

The remaining transitions take place on a detected SCL fall:
- From `ST_ADDR`, once 8 bits are in: to `ST_ADDR_ACK` on a match while not busy, otherwise to `ST_SKIP`.
- From `ST_ADDR_ACK`: to `ST_RD` or `ST_WR`, chosen by the R/W bit.
- From `ST_WR`, once 8 bits are in: to `ST_WR_ACK` if not busy, otherwise to `ST_SKIP`.
- From `ST_WR_ACK`: to `ST_WR`.
- From `ST_RD`, once 8 bits are out: to `ST_RD_ACK`.
- From `ST_RD_ACK`: to `ST_RD` if the master acknowledged, otherwise to `ST_SKIP`.

Top module: `twb_slave`

## Requirements
- R1: After reset, with both bus lines high, `bus_idle` is 1, `sda_oe` is 0, and neither `rx_valid` nor `tx_req` pulses. `bus_idle` is 1 only while the controller is idle and both synchronized lines are high.
- R2: A falling SDA while SCL is high (Start) restarts address reception from any state and discards any partly received byte.
- R3: A rising SDA while SCL is high (Stop) returns the controller to idle from any state, and `bus_idle` becomes 1.
- R4: Bits are sampled on the rising SCL edge, MSB first. `sda_oe` changes only after a detected falling SCL edge, a Start or a Stop.
- R5: The first byte after a Start holds a 7-bit address in bits 7..1 and a read flag in bit 0 (1 = read). It is acknowledged only when bits 7..1 equal `DEV_ADDR`. On a mismatch the slave releases SDA and ignores all bytes until the next Start.
- R6: Every write byte is acknowledged by pulling SDA low for the ninth SCL pulse. It is presented as a one-cycle `rx_valid` pulse with `rx_data`, for any number of bytes.
- R7: If `busy_i` is high when an address or write byte completes, no acknowledge is given and no `rx_valid` is produced. The slave then ignores the bus until the next Start.
- R8: On reads, `tx_data` is captured at the start of each byte and sent MSB first, with SDA pulled low only for 0 bits. `tx_req` pulses for one cycle after each capture.
- R9: If the master pulls SDA low in the ninth clock of a read byte, the next byte follows. If SDA is high in that clock, the slave releases SDA and sends nothing more until a Start or Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Internal programming cycle in progress |
| rx_valid | output | 1 | One-cycle pulse for a completed write byte |
| rx_data | output | 8 | Last received write byte |
| tx_data | input | 8 | Byte to send on the next read byte |
| tx_req | output | 1 | One-cycle pulse: `tx_data` captured, present the next byte |
| bus_idle | output | 1 | Controller idle and both lines high |

## Verification
The bench builds the block with its defaults: 8-bit bytes, `DEV_ADDR` of 0x50 and a two-stage synchronizer. With 7-bit addresses, all 128 addresses can be swept so that every one is checked for acknowledge or silence. The eight-bit byte width keeps long write runs, multi-byte reads ending in a not-acknowledge, and aborts by an early Start in the middle of a byte within a short run. The same runs also cover busy cycles that land on the address byte and on a data byte.

// File: rtl/twb_pkg.sv
package twb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } twb_state_t;
endpackage

// File: rtl/twb_sync.sv
// Synchronizes SCL and SDA and decodes edges and bus conditions.
module twb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    // index 1 = SCL, index 0 = SDA
    logic [DEPTH-1:0][1:0] chain;
    logic [1:0]            prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 2'b11;
        end else begin
            chain <= {chain[DEPTH-2:0], {scl_i, sda_i}};
            prev  <= chain[DEPTH-1];
        end
    end

    assign scl_s     = chain[DEPTH-1][1];
    assign sda_s     = chain[DEPTH-1][0];
    assign scl_rise  = !prev[1] &&  scl_s;
    assign scl_fall  =  prev[1] && !scl_s;
    assign start_det =  prev[1] &&  scl_s &&  prev[0] && !sda_s;
    assign stop_det  =  prev[1] &&  scl_s && !prev[0] &&  sda_s;
endmodule

// File: rtl/twb_shifter.sv
// Shared shift register: shifts in on receive, shifts out MSB first on send.
module twb_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '1;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/twb_slave.sv
module twb_slave #(
    parameter int               BYTE_W      = 8,
    parameter logic [BYTE_W-2:0] DEV_ADDR   = 'h50,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              busy_i,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              bus_idle
);
    import twb_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    twb_state_t state, nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q, mack_q;
    logic              sh_load, sh_shift, sh_bit;
    logic [BYTE_W-1:0] sh_q;
    logic              byte_full, addr_hit, shifting, cond;
    logic              rx_valid_q, tx_req_q;
    logic [BYTE_W-1:0] rx_data_q;

    twb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twb_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(tx_data),
        .shift(sh_shift), .bit_in(sh_bit), .q(sh_q)
    );

    assign byte_full = (cnt == FULL_CNT);
    assign addr_hit  = (sh_q[BYTE_W-1:1] == DEV_ADDR);
    assign shifting  = (state == ST_ADDR) || (state == ST_WR) || (state == ST_RD);
    assign cond      = start_det || stop_det;

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det)
            nxt = ST_ADDR;
        else if (stop_det)
            nxt = ST_IDLE;
        else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_full) nxt = (addr_hit && !busy_i) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: nxt = rw_q ? ST_RD : ST_WR;
                ST_WR:       if (byte_full) nxt = busy_i ? ST_SKIP : ST_WR_ACK;
                ST_WR_ACK:   nxt = ST_WR;
                ST_RD:       if (byte_full) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = mack_q ? ST_RD : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // shifter control
    always_comb begin
        sh_load  = !cond && scl_fall &&
                   (((state == ST_ADDR_ACK) && rw_q) || ((state == ST_RD_ACK) && mack_q));
        sh_shift = 1'b0;
        sh_bit   = sda_s;
        if ((state == ST_ADDR || state == ST_WR) && scl_rise)
            sh_shift = 1'b1;
        else if (state == ST_RD && scl_fall && !byte_full && !cond) begin
            sh_shift = 1'b1;
            sh_bit   = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // bit counter and side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
            tx_req_q   <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            tx_req_q   <= sh_load;
            if (cond)
                cnt <= '0;
            else if (shifting && scl_rise)
                cnt <= cnt + 1'b1;
            else if (shifting && scl_fall && byte_full)
                cnt <= '0;
            if (!cond && state == ST_ADDR && scl_fall && byte_full)
                rw_q <= sh_q[0];
            if (state == ST_RD_ACK && scl_rise)
                mack_q <= !sda_s;
            if (!cond && state == ST_WR && scl_fall && byte_full && !busy_i) begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= sh_q;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe   = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                   ((state == ST_RD) && !sh_q[BYTE_W-1]);
        bus_idle = (state == ST_IDLE) && scl_s && sda_s;
        rx_valid = rx_valid_q;
        rx_data  = rx_data_q;
        tx_req   = tx_req_q;
    end
endmodule

// File: rtl/twb_slave_chk.sv
module twb_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic sda_oe,
    input logic rx_valid,
    input logic tx_req,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic in_ack,
    input logic idle_st
);
    // R4
    oe_change_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R7
    no_busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> !$past(busy_i));

    // R3
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> idle_st);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_st |-> !sda_oe);
endmodule

bind twb_slave twb_slave_chk u_twb_slave_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .tx_req(tx_req), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .in_ack((state == twb_pkg::ST_ADDR_ACK) || (state == twb_pkg::ST_WR_ACK)),
    .idle_st(state == twb_pkg::ST_IDLE)
);

// File: tb/test_twb_slave.sv
`timescale 1ns/1ps
module test_twb_slave;
    localparam logic [6:0] ADDR = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic busy = 1'b0;
    logic [7:0] tx_data;
    logic sda_oe, rx_valid, tx_req, bus_idle;
    logic [7:0] rx_data;
    logic sda_line;

    int total = 0, fails = 0;
    int rx_cnt = 0, tx_cnt = 0;
    logic [7:0] rx_last = 8'h00;

    assign sda_line = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    twb_slave i_twb_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .busy_i(busy), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_data(tx_data), .tx_req(tx_req), .bus_idle(bus_idle)
    );

    function automatic logic [7:0] tx_val(input int n);
        return 8'hA5 + 8'(n * 59);
    endfunction

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_last = rx_data;
            rx_cnt++;
        end
        if (tx_req) begin
            tx_cnt++;
            tx_data = tx_val(tx_cnt);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(6);
        m_sda = 1'b0; tick(6);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop;
        tick(4); m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(6);
        m_sda = 1'b1; tick(6);
    endtask

    task automatic put_bit(input logic b);
        tick(4); m_sda = b; tick(5);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(4); m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(4);
        b = sda_line; tick(4);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        int prev;
        tx_data = tx_val(0);
        tick(5);
        rst_n = 1'b1;
        tick(6);
        // R1 reset state
        chk("R1 bus_idle", bus_idle, 1);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rx pulses", rx_cnt, 0);
        chk("R1 tx pulses", tx_cnt, 0);

        // R5 sweep of every address, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start;
            send_byte({7'(a), 1'b0}, ack);
            bus_stop;
            chk("R5 address ack", ack, (a == ADDR) ? 1 : 0);
        end
        chk("R3 idle after stop", bus_idle, 1);

        // R5 mismatch: data after a wrong address is ignored
        bus_start;
        send_byte({ADDR ^ 7'h01, 1'b0}, ack);
        send_byte(8'h77, ack);
        chk("R5 ignored data ack", ack, 0);
        chk("R5 ignored data rx", rx_cnt, 0);
        bus_stop;

        // R6 write run
        bus_start;
        send_byte({ADDR, 1'b0}, ack);
        chk("R6 addr ack", ack, 1);
        for (int i = 0; i < 20; i++) begin
            d = 8'(i * 29 + 7);
            send_byte(d, ack);
            chk("R6 data ack", ack, 1);
            chk("R6 rx_data", rx_last, d);
            chk("R6 rx count", rx_cnt, i + 1);
        end
        bus_stop;
        chk("R3 idle after write", bus_idle, 1);

        // R7 busy on address and on data
        busy = 1'b1;
        bus_start;
        send_byte({ADDR, 1'b0}, ack);
        chk("R7 busy addr", ack, 0);
        bus_stop;
        busy = 1'b0;
        prev = rx_cnt;
        bus_start;
        send_byte({ADDR, 1'b0}, ack);
        chk("R7 addr ack", ack, 1);
        busy = 1'b1;
        send_byte(8'h5A, ack);
        chk("R7 busy data ack", ack, 0);
        busy = 1'b0;
        send_byte(8'h5B, ack);
        chk("R7 skip after busy", ack, 0);
        chk("R7 no rx", rx_cnt, prev);
        bus_stop;

        // R2 abort by Start in mid-byte
        prev = rx_cnt;
        bus_start;
        send_byte({ADDR, 1'b0}, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start;
        send_byte({ADDR, 1'b0}, ack);
        chk("R2 addr after restart", ack, 1);
        send_byte(8'h3C, ack);
        chk("R2 data ack", ack, 1);
        chk("R2 rx data", rx_last, 8'h3C);
        chk("R2 rx count", rx_cnt, prev + 1);
        bus_stop;

        // R8 / R9 read run ending with a not-acknowledge
        bus_start;
        send_byte({ADDR, 1'b1}, ack);
        chk("R8 read addr ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(d, k < 3);
            chk("R8 read byte", d, tx_val(k));
        end
        chk("R8 tx_req count", tx_cnt, 4);
        get_bit(ack);
        chk("R9 released after nack", ack, 1);
        chk("R9 no further capture", tx_cnt, 4);
        bus_stop;
        chk("R3 idle after read", bus_idle, 1);
        chk("R4 released at end", sda_oe, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule